// File: doc/BRIEF.md
# Sound Unit Channel Enable and Status Register

This block is the shared control and status register of a five-channel sound unit. The channels are two pulse channels, a triangle channel, a noise channel and a sample-playback channel. A write latches one enable bit per channel. The same write also sends one-cycle side-effect strobes to the channels: it zeroes the length counters of the disabled tone channels, and it stops or restarts the sample channel.

A read returns a status byte. The byte is built from each channel's activity input and from two interrupt flags. The read-clear behaviour is asymmetric. A read clears only the frame interrupt flag. The sample interrupt flag is cleared by any write. When a flag is set in the same cycle as the operation that would clear it, the set wins. In that case the read still reports the flag as 1.

The channels themselves are outside this block. It only holds the enables and the flags, and it turns register accesses into strobes.

Top module: `snd_ctl_status`

## Requirements
- R1: After reset, `chan_en`, `len_clear`, `smp_stop`, `smp_restart`, `frame_irq` and `smp_irq` are all 0.
- R2: A write loads `wr_data[4:0]` into `chan_en` on the clock edge of the write, so the new value is visible the next cycle. The bit mapping is bit 0 = pulse 1, bit 1 = pulse 2, bit 2 = triangle, bit 3 = noise, bit 4 = sample channel. Bits 7..5 of `wr_data` have no effect on any output.
- R3: For each i in 0..3, a write with `wr_data[i]` = 0 pulses `len_clear[i]` high for exactly the one cycle after the write. Without a write, `len_clear` is 0.
- R4: A write with `wr_data[4]` = 0 pulses `smp_stop` high for exactly the one cycle after the write.
- R5: A write with `wr_data[4]` = 1 pulses `smp_restart` for one cycle after the write, but only if `smp_bytes_nz` is 0 during the write cycle. Otherwise no restart is issued.
- R6: `smp_irq_set` sets the sample flag. Any write clears it, unless `smp_irq_set` is high in the same cycle, in which case the flag stays set.
- R7: While `rd_en` is high, `rd_data` is available in the same cycle. Its layout is bit 7 = sample flag, bit 6 = frame flag, bit 5 = 0, bit 4 = `smp_bytes_nz`, bits 3..0 = `len_nz[3:0]`. A flag bit also reads 1 if its set input is high in that cycle. When `rd_en` is low, `rd_data` is 0.
- R8: A read clears the frame flag from the next cycle on. A read leaves the sample flag unchanged.
- R9: If `frame_irq_set` is high in the same cycle as a read, the read returns bit 6 = 1 and `frame_irq` is still 1 in the next cycle.
- R10: `frame_irq_set` sets the frame flag, and the flag holds until a read clears it. `frame_irq` and `smp_irq` show the flag states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Status byte, same cycle as `rd_en` |
| len_nz | input | 4 | Length counter nonzero: noise, triangle, pulse 2, pulse 1 |
| smp_bytes_nz | input | 1 | Sample channel has bytes remaining |
| frame_irq_set | input | 1 | Sets the frame interrupt flag |
| smp_irq_set | input | 1 | Sets the sample interrupt flag |
| chan_en | output | 5 | Latched channel enables |
| len_clear | output | 4 | One-cycle length-counter clear strobes |
| smp_stop | output | 1 | One-cycle sample stop strobe |
| smp_restart | output | 1 | One-cycle sample restart strobe |
| frame_irq | output | 1 | Frame interrupt flag |
| smp_irq | output | 1 | Sample interrupt flag |

## Verification
The read byte is combinational, so it is due in the cycle where `rd_en` is high. The bench samples it 1 ns after it drives the inputs on the falling edge. The enables, strobes and flags are registered once, so they are due one cycle after the access. The bench checks them at the next falling edge, before it drives new inputs, against a model that was advanced by one step. The directed cases place a set in the same cycle as the clearing access, so both orders of the set/clear race are compared.

// File: rtl/snd_ctl_pkg.sv
package snd_ctl_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned N_TONE   = 4;
  localparam int unsigned N_CHAN   = N_TONE + 1;
  localparam int unsigned SMP_BIT  = N_TONE;
  localparam int unsigned FRM_RBIT = 6;
  localparam int unsigned SMP_RBIT = 7;

  typedef struct packed {
    logic [N_TONE-1:0] len_clear;
    logic              stop;
    logic              restart;
  } strobe_t;
endpackage

// File: rtl/sc_rst_sync.sv
module sc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sc_wr_decode.sv
module sc_wr_decode
  import snd_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              smp_bytes_nz,
  output logic [N_CHAN-1:0] chan_en,
  output strobe_t           strobes
);
  logic [N_CHAN-1:0] en_q;
  strobe_t           stb_d, stb_q;

  always_comb begin
    stb_d = '0;
    if (wr_en) begin
      for (int i = 0; i < int'(N_TONE); i++) stb_d.len_clear[i] = ~wr_data[i];
      stb_d.stop    = ~wr_data[SMP_BIT];
      stb_d.restart =  wr_data[SMP_BIT] & ~smp_bytes_nz;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= wr_data[N_CHAN-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= '0;
    else        stb_q <= stb_d;
  end

  assign chan_en = en_q;
  assign strobes = stb_q;
endmodule

// File: rtl/sc_irq_flag.sv
module sc_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o,
  output logic peek_o
);
  logic flag_d, flag_q;

  always_comb flag_d = set_i | (flag_q & ~clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
  assign peek_o = flag_q | set_i;
endmodule

// File: rtl/snd_ctl_status.sv
module snd_ctl_status
  import snd_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [N_TONE-1:0] len_nz,
  input  logic              smp_bytes_nz,
  input  logic              frame_irq_set,
  input  logic              smp_irq_set,
  output logic [N_CHAN-1:0] chan_en,
  output logic [N_TONE-1:0] len_clear,
  output logic              smp_stop,
  output logic              smp_restart,
  output logic              frame_irq,
  output logic              smp_irq
);
  logic    rst_int_n;
  strobe_t stb;
  logic    frm_peek, smp_peek;

  sc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n));

  sc_wr_decode u_wr (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_data(wr_data),
    .smp_bytes_nz(smp_bytes_nz), .chan_en(chan_en), .strobes(stb)
  );

  // frame flag clears on read, sample flag clears on write
  sc_irq_flag u_frm (
    .clk(clk), .rst_n(rst_int_n), .set_i(frame_irq_set), .clr_i(rd_en),
    .flag_o(frame_irq), .peek_o(frm_peek)
  );
  sc_irq_flag u_smp (
    .clk(clk), .rst_n(rst_int_n), .set_i(smp_irq_set), .clr_i(wr_en),
    .flag_o(smp_irq), .peek_o(smp_peek)
  );

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      rd_data[N_TONE-1:0] = len_nz;
      rd_data[SMP_BIT]    = smp_bytes_nz;
      rd_data[FRM_RBIT]   = frm_peek;
      rd_data[SMP_RBIT]   = smp_peek;
    end
  end

  assign len_clear   = stb.len_clear;
  assign smp_stop    = stb.stop;
  assign smp_restart = stb.restart;
endmodule

// File: rtl/snd_ctl_status_chk.sv
module snd_ctl_status_chk
  import snd_ctl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [BYTE_W-1:0] wr_data,
  input logic              rd_en,
  input logic [BYTE_W-1:0] rd_data,
  input logic              smp_bytes_nz,
  input logic              frame_irq_set,
  input logic              smp_irq_set,
  input logic [N_CHAN-1:0] chan_en,
  input logic [N_TONE-1:0] len_clear,
  input logic              smp_stop,
  input logic              smp_restart,
  input logic              frame_irq,
  input logic              smp_irq
);
  a_r2_en_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> chan_en == $past(wr_data[N_CHAN-1:0]));
  a_r3_len_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> len_clear == ~$past(wr_data[N_TONE-1:0]));
  a_r3_no_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> len_clear == '0 && !smp_stop && !smp_restart);
  a_r4_stop_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_stop && smp_restart));
  a_r5_busy_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && smp_bytes_nz |=> !smp_restart);
  a_r6_wr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !smp_irq_set |=> !smp_irq);
  a_r7_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[5]);
  a_r8_rd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !frame_irq_set |=> !frame_irq);
  a_r8_smp_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en && smp_irq |=> smp_irq);
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq_set |=> frame_irq);
endmodule

bind snd_ctl_status snd_ctl_status_chk u_chk (
  .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .smp_bytes_nz(smp_bytes_nz),
  .frame_irq_set(frame_irq_set), .smp_irq_set(smp_irq_set),
  .chan_en(chan_en), .len_clear(len_clear), .smp_stop(smp_stop),
  .smp_restart(smp_restart), .frame_irq(frame_irq), .smp_irq(smp_irq)
);

// File: tb/snd_ctl_status_tb.sv
module snd_ctl_status_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [3:0] len_nz = 4'h0;
  logic       smp_bytes_nz = 1'b0, frame_irq_set = 1'b0, smp_irq_set = 1'b0;
  logic [7:0] rd_data;
  logic [4:0] chan_en;
  logic [3:0] len_clear;
  logic       smp_stop, smp_restart, frame_irq, smp_irq;

  int n_chk = 0, n_bad = 0;
  logic [4:0] m_en = '0;
  logic [3:0] m_lc = '0;
  logic       m_stop = 0, m_rs = 0, m_fq = 0, m_sq = 0;

  always #2.5 clk = ~clk;

  snd_ctl_status u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .len_nz(len_nz), .smp_bytes_nz(smp_bytes_nz),
    .frame_irq_set(frame_irq_set), .smp_irq_set(smp_irq_set), .chan_en(chan_en),
    .len_clear(len_clear), .smp_stop(smp_stop), .smp_restart(smp_restart),
    .frame_irq(frame_irq), .smp_irq(smp_irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic r, w, input logic [3:0] l,
                                        input logic b, fs, ss);
    logic [7:0] v = 8'h00;
    if (r) v = {m_sq | ss, m_fq | fs, 1'b0, b, l};
    return v;
  endfunction

  task automatic check_regs();
    check("R2 chan_en", {3'b0, chan_en}, {3'b0, m_en});
    check("R3 len_clear", {4'b0, len_clear}, {4'b0, m_lc});
    check("R4 smp_stop", {7'b0, smp_stop}, {7'b0, m_stop});
    check("R5 smp_restart", {7'b0, smp_restart}, {7'b0, m_rs});
    check("R10 frame_irq", {7'b0, frame_irq}, {7'b0, m_fq});
    check("R6 smp_irq", {7'b0, smp_irq}, {7'b0, m_sq});
  endtask

  // one cycle: called at a falling edge
  task automatic step(input logic w, input logic [7:0] d, input logic r,
                      input logic [3:0] l, input logic b, fs, ss);
    check_regs();
    wr_en = w; wr_data = d; rd_en = r; len_nz = l;
    smp_bytes_nz = b; frame_irq_set = fs; smp_irq_set = ss;
    #1;
    check("R7 rd_data", rd_data, exp_rd(r, w, l, b, fs, ss));
    if (w) begin
      m_en = d[4:0]; m_lc = ~d[3:0]; m_stop = ~d[4]; m_rs = d[4] & ~b;
    end else begin
      m_lc = '0; m_stop = 0; m_rs = 0;
    end
    m_fq = fs | (m_fq & ~r);
    m_sq = ss | (m_sq & ~w);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", {chan_en, len_clear[2:0]}, 8'h00);
    check("R1 reset flags", {4'b0, len_clear[3], smp_stop, frame_irq, smp_irq}, 8'h00);
    // R2: upper bits ignored, everything disabled
    step(1, 8'hE0, 0, 4'h0, 0, 0, 0);
    step(1, 8'h1F, 0, 4'h0, 0, 0, 0);   // R5 restart when idle
    step(1, 8'h1F, 0, 4'h0, 1, 0, 0);   // R5 no restart when busy
    step(1, 8'h0A, 0, 4'h5, 1, 0, 0);   // R3 R4 mixed
    step(0, 8'h00, 0, 4'h0, 0, 0, 0);
    // R9 set during read survives
    step(0, 8'h00, 1, 4'hF, 1, 1, 0);
    step(0, 8'h00, 0, 4'h0, 0, 0, 0);
    // R8 read clears frame, keeps sample flag
    step(0, 8'h00, 0, 4'h0, 0, 0, 1);
    step(0, 8'h00, 1, 4'h3, 0, 0, 0);
    step(0, 8'h00, 1, 4'h0, 0, 0, 0);
    // R6 write clears sample flag, set during write wins
    step(1, 8'h10, 0, 4'h0, 0, 0, 1);
    step(1, 8'h10, 0, 4'h0, 0, 0, 0);
    step(0, 8'h00, 0, 4'h0, 0, 0, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) == 0, 8'($urandom), ($urandom % 3) == 0, 4'($urandom),
           1'($urandom), ($urandom % 5) == 0, ($urandom % 5) == 0);
    end
    check_regs();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule